// File: doc/BRIEF.md
# Ahead-Indexed Skewed Branch Direction Predictor

This block predicts the direction of conditional branches for a fetch front end that produces one fetch block per cycle. The prediction for a block cannot wait for that block's own address. Table access therefore starts four cycles early, from the address and global history of an older block. Each cycle in between, the front end presents a small vector of path bits for the block it has just produced. Every pipelined index takes exactly one of those bits per stage, and each bank takes a different bit, so the banks see different views of the recent path.

The storage has four banks of 2-bit saturating counters. Bank 0 is a bimodal bank indexed by address only. Banks 1 and 2 are global banks whose indices mix the address with the history, each rotated differently. Bank 3 is a chooser that picks between the bimodal vote and the majority vote of banks 0 to 2. A separate update port gives the full context of a resolved branch (address, history, the three path vectors) and its outcome. The tables are trained from that port independently of the prediction pipeline.

Top module: `aheadPredictor`

## Requirements
- R1: A request accepted in a cycle with `stall` low yields `predValid` high exactly 4 unstalled cycles later. `predValid` is low in the three cycles between.
- R2: After reset `predValid` is low, every voter counter holds 1 (weak not-taken) and every chooser counter holds 2. An untrained context therefore predicts not-taken with `predVotes` = 000 and `predUseMaj` = 1.
- R3: An update whose final prediction disagrees with the outcome moves all three voter counters of that context one step toward the outcome.
- R4: A `pathIn` bit k presented s cycles after the request (s = 1, 2, 3) enters the index of bank (k − s) mod 4 only. `predVotes[b]` is the counter MSB of voter bank b: 0 is bimodal, 1 and 2 are global.
- R5: While `stall` is high, no pipeline stage moves, `pathIn` and the request inputs are ignored, and every prediction output holds its value.
- R6: Counters saturate at 3 and at 0 and never wrap.
- R7: When the final prediction was correct, only the voter banks whose vote matched the outcome are strengthened. A disagreeing bank keeps its counter.
- R8: The final direction is the majority vote when the chooser counter MSB is 1, otherwise the bimodal vote. The chooser is written only when the bimodal and majority votes differ, and it steps toward the majority if the majority matched the outcome, else toward the bimodal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freezes the prediction pipeline |
| reqValid | input | 1 | Starts a prediction from an older block's context |
| reqAddr | input | ADDR_W | Address of the indexing block |
| reqHist | input | HIST_W | Global history of the indexing block |
| pathIn | input | 4 | Path bits of the block produced this cycle |
| updValid | input | 1 | Update strobe |
| updAddr | input | ADDR_W | Update context address |
| updHist | input | HIST_W | Update context history |
| updPath | input | 12 | Path vectors of stages 1..3, stage s at bits [4(s−1) +: 4] |
| updTaken | input | 1 | Resolved direction |
| predValid | output | 1 | Prediction present |
| predTaken | output | 1 | Predicted direction |
| predVotes | output | 3 | Per-voter-bank vote |
| predUseMaj | output | 1 | Chooser selected the majority |

## Verification
The hardest situation to reach is one where the bimodal and global banks of a single context disagree. That is the only case in which the chooser moves and in which a correct prediction must leave a bank untouched. The stimulus gets there through the path bits. It first trains a base context, then replays it with a single path bit flipped so that exactly one bank lands on an untrained entry. The flipped context is then trained in both directions, and the chooser's effect is shown on the unflipped base context, which shares the chooser and global entries.

// File: rtl/aheadPredPkg.sv
package aheadPredPkg;
  // bank 0 bimodal, banks 1..2 global, bank 3 chooser
  localparam int NUM_BANKS   = 4;
  localparam int NUM_VOTERS  = 3;
  localparam int META_BANK   = 3;
  localparam int FOLD_STAGES = 3;
  localparam int PATH_W      = NUM_BANKS;

  typedef struct packed {
    logic                  advance;
    logic [NUM_VOTERS-1:0] wrBank;
    logic                  metaWr;
    logic                  metaUp;
  } ctrlStrobe_t;
endpackage

// File: rtl/aheadPredDatapath.sv
module aheadPredDatapath
  import aheadPredPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int HIST_W      = 16,
  parameter int LOG_ENTRIES = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strb,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [HIST_W-1:0]             reqHist,
  input  logic [PATH_W-1:0]             pathIn,
  input  logic [ADDR_W-1:0]             updAddr,
  input  logic [HIST_W-1:0]             updHist,
  input  logic [PATH_W*FOLD_STAGES-1:0] updPath,
  input  logic                          updTaken,
  output logic [NUM_VOTERS-1:0]         updVotes,
  output logic                          updMetaHi,
  output logic                          predTaken,
  output logic [NUM_VOTERS-1:0]         predVotes,
  output logic                          predUseMaj
);
  localparam int IDX_W   = LOG_ENTRIES;
  localparam int ENTRIES = 1 << LOG_ENTRIES;

  function automatic logic [IDX_W-1:0] foldAddr(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ a[i];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] foldHist(input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < HIST_W; i++) r[i % IDX_W] = r[i % IDX_W] ^ h[i];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] rotl(input logic [IDX_W-1:0] v, input int n);
    logic [IDX_W-1:0] r;
    r = v;
    for (int i = 0; i < n; i++) r = {r[IDX_W-2:0], r[IDX_W-1]};
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] baseIdx(input int bank,
                                               input logic [ADDR_W-1:0] a,
                                               input logic [HIST_W-1:0] h);
    if (bank == 0) return foldAddr(a);
    return foldAddr(a) ^ rotl(foldHist(h), bank - 1);
  endfunction

  function automatic logic [IDX_W-1:0] foldIn(input logic [IDX_W-1:0] idx,
                                              input int stage, input logic b);
    logic [IDX_W-1:0] m;
    m = '0;
    m[stage-1] = b;
    return idx ^ m;
  endfunction

  function automatic logic [1:0] satStep(input logic [1:0] c, input logic up);
    if (up)  return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // counter tables, one per bank
  logic [1:0] tbl [NUM_BANKS][ENTRIES];

  // pipelined indices: column select, wordline select, final logic
  logic [IDX_W-1:0] colIdx  [NUM_BANKS];
  logic [IDX_W-1:0] wordIdx [NUM_BANKS];
  logic [IDX_W-1:0] lateIdx [NUM_BANKS];
  logic [IDX_W-1:0] finIdx  [NUM_BANKS];
  logic [IDX_W-1:0] updIdx  [NUM_BANKS];
  logic [1:0]       rdCnt   [NUM_BANKS];
  logic [1:0]       updCnt  [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        colIdx[b]  <= '0;
        wordIdx[b] <= '0;
        lateIdx[b] <= '0;
      end
    end else if (strb.advance) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        colIdx[b]  <= baseIdx(b, reqAddr, reqHist);
        wordIdx[b] <= foldIn(colIdx[b], 1, pathIn[(b + 1) % PATH_W]);
        lateIdx[b] <= foldIn(wordIdx[b], 2, pathIn[(b + 2) % PATH_W]);
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      finIdx[b] = foldIn(lateIdx[b], 3, pathIn[(b + 3) % PATH_W]);
      updIdx[b] = foldIn(foldIn(foldIn(baseIdx(b, updAddr, updHist),
                    1, updPath[0*PATH_W + (b + 1) % PATH_W]),
                    2, updPath[1*PATH_W + (b + 2) % PATH_W]),
                    3, updPath[2*PATH_W + (b + 3) % PATH_W]);
      rdCnt[b]  = tbl[b][finIdx[b]];
      updCnt[b] = tbl[b][updIdx[b]];
    end
  end

  for (genvar v = 0; v < NUM_VOTERS; v++) begin : g_vote
    assign updVotes[v] = updCnt[v][1];
  end
  assign updMetaHi = updCnt[META_BANK][1];

  // table write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++)
        for (int e = 0; e < ENTRIES; e++)
          tbl[b][e] <= (b == META_BANK) ? 2'd2 : 2'd1;
    end else begin
      for (int v = 0; v < NUM_VOTERS; v++)
        if (strb.wrBank[v]) tbl[v][updIdx[v]] <= satStep(updCnt[v], updTaken);
      if (strb.metaWr)
        tbl[META_BANK][updIdx[META_BANK]] <= satStep(updCnt[META_BANK], strb.metaUp);
    end
  end

  // final selection
  logic [NUM_VOTERS-1:0] rdVotes;
  logic                  rdMaj;
  always_comb begin
    for (int v = 0; v < NUM_VOTERS; v++) rdVotes[v] = rdCnt[v][1];
    rdMaj = (rdVotes[0] & rdVotes[1]) | (rdVotes[0] & rdVotes[2]) | (rdVotes[1] & rdVotes[2]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predTaken  <= 1'b0;
      predVotes  <= '0;
      predUseMaj <= 1'b0;
    end else if (strb.advance) begin
      predVotes  <= rdVotes;
      predUseMaj <= rdCnt[META_BANK][1];
      predTaken  <= rdCnt[META_BANK][1] ? rdMaj : rdVotes[0];
    end
  end

  // R5: outputs frozen while stalled
  assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> ($stable(predTaken) && $stable(predVotes) && $stable(predUseMaj)));

  // R7: a bank voting against the outcome is written only when all are (misprediction)
  assert_keep_dissent_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrBank & (updVotes ^ {NUM_VOTERS{updTaken}})) != '0) |-> (strb.wrBank == '1));

  // R8: chooser trained only when bimodal and majority differ
  assert_meta_on_split_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.metaWr |-> (updVotes != '0 && updVotes != '1));
endmodule

// File: rtl/aheadPredControl.sv
module aheadPredControl
  import aheadPredPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stall,
  input  logic                  reqValid,
  input  logic                  updValid,
  input  logic                  updTaken,
  input  logic [NUM_VOTERS-1:0] updVotes,
  input  logic                  updMetaHi,
  output ctrlStrobe_t           strb,
  output logic                  predValid
);
  logic [FOLD_STAGES-1:0] stageValid;
  logic                   updMaj, updFinal, updCorrect;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
      predValid  <= 1'b0;
    end else if (!stall) begin
      stageValid <= {stageValid[FOLD_STAGES-2:0], reqValid};
      predValid  <= stageValid[FOLD_STAGES-1];
    end
  end

  always_comb begin
    updMaj     = (updVotes[0] & updVotes[1]) | (updVotes[0] & updVotes[2]) |
                 (updVotes[1] & updVotes[2]);
    updFinal   = updMetaHi ? updMaj : updVotes[0];
    updCorrect = (updFinal == updTaken);
    strb.advance = !stall;
    strb.wrBank  = '0;
    if (updValid)
      strb.wrBank = updCorrect ? ~(updVotes ^ {NUM_VOTERS{updTaken}}) : '1;
    strb.metaWr = updValid && (updVotes[0] != updMaj);
    strb.metaUp = (updMaj == updTaken);
  end

  // R1: last stage valid and no stall leads to a prediction next cycle
  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && stageValid[FOLD_STAGES-1]) |=> predValid);

  // R2: nothing is presented right after reset
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predValid);

  // R5: valid held through a stall
  assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(predValid));
endmodule

// File: rtl/aheadPredictor.sv
module aheadPredictor
  import aheadPredPkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int HIST_W      = 16,
  parameter int LOG_ENTRIES = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          stall,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [HIST_W-1:0]             reqHist,
  input  logic [PATH_W-1:0]             pathIn,
  input  logic                          updValid,
  input  logic [ADDR_W-1:0]             updAddr,
  input  logic [HIST_W-1:0]             updHist,
  input  logic [PATH_W*FOLD_STAGES-1:0] updPath,
  input  logic                          updTaken,
  output logic                          predValid,
  output logic                          predTaken,
  output logic [NUM_VOTERS-1:0]         predVotes,
  output logic                          predUseMaj
);
  ctrlStrobe_t           strb;
  logic [NUM_VOTERS-1:0] updVotes;
  logic                  updMetaHi;

  aheadPredControl ctrl_i (
    .clk(clk), .rstN(rstN), .stall(stall), .reqValid(reqValid),
    .updValid(updValid), .updTaken(updTaken), .updVotes(updVotes),
    .updMetaHi(updMetaHi), .strb(strb), .predValid(predValid)
  );

  aheadPredDatapath #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .LOG_ENTRIES(LOG_ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqHist(reqHist),
    .pathIn(pathIn), .updAddr(updAddr), .updHist(updHist), .updPath(updPath),
    .updTaken(updTaken), .updVotes(updVotes), .updMetaHi(updMetaHi),
    .predTaken(predTaken), .predVotes(predVotes), .predUseMaj(predUseMaj)
  );
endmodule

// File: tb/aheadPredictor_tb_top.sv
module aheadPredictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 1'b0;
  logic        rstN, stall, reqValid, updValid, updTaken;
  logic [15:0] reqAddr, reqHist, updAddr, updHist;
  logic [3:0]  pathIn;
  logic [11:0] updPath;
  logic        predValid, predTaken, predUseMaj;
  logic [2:0]  predVotes;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aheadPredictor dut_i (
    .clk(clk), .rstN(rstN), .stall(stall), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqHist(reqHist), .pathIn(pathIn), .updValid(updValid), .updAddr(updAddr),
    .updHist(updHist), .updPath(updPath), .updTaken(updTaken), .predValid(predValid),
    .predTaken(predTaken), .predVotes(predVotes), .predUseMaj(predUseMaj)
  );

  // contexts: X = 1234/00f0, Z = 0abc/5a5a
  // op 0 query, 1 update
  localparam logic        V_OP   [NV] = '{0,1,0,0,0,0,1,0,1,1,0,0,1,1,1,1,0,1,1,1,1,0};
  localparam logic [15:0] V_ADDR [NV] = '{16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,
    16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h1234,16'h0abc,16'h0abc,16'h0abc,16'h0abc,
    16'h0abc,16'h0abc,16'h0abc,16'h0abc,16'h0abc,16'h0abc};
  localparam logic [15:0] V_HIST [NV] = '{16'h00f0,16'h00f0,16'h00f0,16'h00f0,16'h00f0,16'h00f0,
    16'h00f0,16'h00f0,16'h00f0,16'h00f0,16'h00f0,16'h00f0,16'h5a5a,16'h5a5a,16'h5a5a,16'h5a5a,
    16'h5a5a,16'h5a5a,16'h5a5a,16'h5a5a,16'h5a5a,16'h5a5a};
  localparam logic [3:0]  V_P1 [NV] = '{0,0,0,2,0,0,2,2,2,2,2,0,0,0,0,0,0,0,0,0,0,0};
  localparam logic [3:0]  V_P2 [NV] = '{0,0,0,0,8,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};
  localparam logic [3:0]  V_P3 [NV] = '{0,0,0,0,0,2,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0};
  localparam logic        V_TK [NV] = '{0,1,0,0,0,0,1,0,0,0,0,0,1,1,1,0,0,0,0,0,1,0};
  localparam logic        V_ET [NV] = '{0,0,1,1,1,1,0,1,0,0,0,1,0,0,0,0,1,0,0,0,0,0};
  localparam logic [2:0]  V_EV [NV] = '{3'b000,0,3'b111,3'b110,3'b101,3'b011,0,3'b110,0,0,
    3'b000,3'b001,0,0,0,0,3'b111,0,0,0,0,3'b000};
  localparam logic        V_EU [NV] = '{1,0,1,1,1,1,0,1,0,0,0,0,0,0,0,0,1,0,0,0,0,1};
  // requirement checked by each query: R2,R3,R4,R4,R4,R7,R8,R8,R6,R6
  localparam int          V_REQ[NV] = '{2,3,3,4,4,4,7,7,8,8,8,8,6,6,6,6,6,6,6,6,6,6};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic query(input logic [15:0] a, input logic [15:0] h,
                       input logic [3:0] p1, input logic [3:0] p2, input logic [3:0] p3);
    reqValid = 1'b1; reqAddr = a; reqHist = h; pathIn = 4'h0;
    @(negedge clk);
    reqValid = 1'b0; pathIn = p1;
    @(negedge clk);
    pathIn = p2;
    @(negedge clk);
    pathIn = p3;
    @(negedge clk);
    pathIn = 4'h0;
  endtask

  task automatic update(input logic [15:0] a, input logic [15:0] h, input logic [3:0] p1,
                        input logic [3:0] p2, input logic [3:0] p3, input logic tk);
    updValid = 1'b1; updAddr = a; updHist = h; updPath = {p3, p2, p1}; updTaken = tk;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; stall = 1'b0; reqValid = 1'b0; reqAddr = '0; reqHist = '0; pathIn = '0;
    updValid = 1'b0; updAddr = '0; updHist = '0; updPath = '0; updTaken = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset valid", {7'd0, predValid}, 8'd0);

    // R1: latency from request to valid
    reqValid = 1'b1; reqAddr = 16'h1234; reqHist = 16'h00f0;
    @(negedge clk);
    reqValid = 1'b0;
    for (int c = 1; c <= 5; c++) begin
      check($sformatf("R1 valid cycle %0d", c), {7'd0, predValid}, (c == 4) ? 8'd1 : 8'd0);
      @(negedge clk);
    end

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      if (V_OP[i]) begin
        update(V_ADDR[i], V_HIST[i], V_P1[i], V_P2[i], V_P3[i], V_TK[i]);
      end else begin
        query(V_ADDR[i], V_HIST[i], V_P1[i], V_P2[i], V_P3[i]);
        check($sformatf("R%0d vec %0d result", V_REQ[i], i),
              {3'd0, predValid, predTaken, predVotes},
              {3'd0, 1'b1, V_ET[i], V_EV[i]});
        check($sformatf("R%0d vec %0d chooser", V_REQ[i], i), {7'd0, predUseMaj}, {7'd0, V_EU[i]});
      end
    end

    // R5: stall in mid-flight with junk path bits; result must match unstalled (bim T, useMaj 0)
    reqValid = 1'b1; reqAddr = 16'h1234; reqHist = 16'h00f0; pathIn = 4'h0;
    @(negedge clk);
    reqValid = 1'b0; pathIn = 4'h0;
    @(negedge clk);
    stall = 1'b1; pathIn = 4'hf; reqValid = 1'b1; reqAddr = 16'hffff;
    @(negedge clk);
    check("R5 no advance during stall", {7'd0, predValid}, 8'd0);
    stall = 1'b0; reqValid = 1'b0; pathIn = 4'h8;
    @(negedge clk);
    pathIn = 4'h0;
    @(negedge clk);
    check("R5 stalled result", {3'd0, predValid, predTaken, predVotes, predUseMaj},
          {3'd0, 1'b1, 1'b1, 3'b001, 1'b0});
    stall = 1'b1; pathIn = 4'hf;
    @(negedge clk);
    check("R5 outputs held", {3'd0, predValid, predTaken, predVotes, predUseMaj},
          {3'd0, 1'b1, 1'b1, 3'b001, 1'b0});
    stall = 1'b0; pathIn = 4'h0;
    @(negedge clk);
    check("R5 released", {7'd0, predValid}, 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule